// File: doc/BRIEF.md
# Output Fault Shutdown with Inrush Blanking

This block protects a bank of low-side output drivers from overload. Each channel has a comparator flag that is high when the output pin sits above the fault threshold. A pin that stays high while its channel is commanded on points to a short or an overload. When this happens the block raises a one-cycle clear pulse for that channel, and the external output latch uses the pulse to switch the channel off. The block clears each channel on its own, so a fault on one output never disturbs the others.

A new command is committed to the output latch with a single-cycle strobe. Each strobe starts a blanking window of a fixed number of clock cycles. While the window runs, faults cannot shut anything down, so loads with high inrush current can start. A strobe that arrives inside a running window starts the count again from the full length. A separate global-clear input forces clear pulses on every channel whether or not blanking is running.

All pins are plain level control and status signals sampled on the rising clock edge, so the block has no valid/ready handshake and applies no back-pressure. Every output is registered: a clear pulse appears in the cycle after the condition that causes it.

Top module: `ovl_shutdown`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `clr_o` is all zeros and `blank_o` is 0. A reset during blanking ends the window at once.
- R2: A cycle with `commit_i` = 1 makes `blank_o` high from the next cycle for exactly `BLANK_CYC` cycles, provided no further commit arrives.
- R3: A commit while `blank_o` is high restarts the window, which then lasts a full `BLANK_CYC` cycles counted from the new commit.
- R4: No fault clear is produced from a cycle where `blank_o` is 1 or `commit_i` is 1.
- R5: Outside blanking, if channel i has `on_i[i]` = 1 (1 means commanded on) and `high_i[i]` = 1 (1 means pin above threshold), then `clr_o[i]` = 1 in the next cycle. Bit i of each bus belongs to channel i.
- R6: Channels are judged independently. Only channels that meet the fault condition themselves get a clear.
- R7: A channel with `on_i[i]` = 0 never gets a fault clear, whatever the state of `high_i[i]`.
- R8: A fault event gives a single clear pulse. The channel can fault again only after a commit, or after one cycle in which it is seen off.
- R9: `zap_i` = 1 sets all bits of `clr_o` in the next cycle, even during blanking. It disarms every channel until that channel is seen off or a commit occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_i | input | 1 | One-cycle strobe: new command committed to the output latch |
| zap_i | input | 1 | Global clear request for all channels |
| on_i | input | NCH | Latched command per channel, 1 = on |
| high_i | input | NCH | Comparator flag per channel, 1 = pin above fault threshold |
| clr_o | output | NCH | One-cycle clear pulse per channel, sent to the output latch |
| blank_o | output | 1 | High while the blanking window runs |

## Verification
Faults are applied in three situations: outside blanking, inside blanking, and in the commit cycle. This separates real shutdowns from inrush that must be tolerated. Commanded-off channels are driven with their comparator flags high, to show that an open or off channel is never cleared. Mixed channel patterns such as 0xC3 on with 0x41 high show that channels are judged one by one. Repeated faults with no re-arm, a commit repeated inside the window, and a global clear during blanking separate single-pulse behaviour, restart of the window, and the forced clear path.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // width of a down-counter able to hold the value n
  function automatic int cnt_w(input int n);
    if (n < 2) return 1;
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ovl_blank_timer.sv
module ovl_blank_timer #(
  parameter int BLANK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  output logic blank_o
);
  localparam int CW = ovl_pkg::cnt_w(BLANK_CYC);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q;

  // a commit loads the full window, including a commit inside a running window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (commit_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign blank_o = (cnt_q != '0);

  // R2: the window is open in the cycle right after a commit
  p_commit_blanks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> blank_o);

  // R3: the window never runs out while commits keep arriving
  p_restart_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_o && commit_i) |=> (cnt_q == LOAD));
endmodule

// File: rtl/ovl_chan_guard.sv
module ovl_chan_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  input  logic blank_i,
  input  logic zap_i,
  input  logic on_i,
  input  logic high_i,
  output logic clr_o
);
  logic armed_q;
  logic fault;

  assign fault = armed_q && on_i && high_i && !blank_i && !commit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      clr_o   <= 1'b0;
    end else begin
      clr_o   <= fault || zap_i;
      armed_q <= commit_i || (!on_i && !zap_i) || (armed_q && !fault && !zap_i);
    end
  end

  // R7: an off channel is never shut down by a fault
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_i && !zap_i) |=> !clr_o);

  // R8: a clear is never followed by a second one without re-arming
  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o && !zap_i) |=> !clr_o);
endmodule

// File: rtl/ovl_shutdown.sv
module ovl_shutdown #(
  parameter int NCH       = 8,
  parameter int BLANK_CYC = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit_i,
  input  logic           zap_i,
  input  logic [NCH-1:0] on_i,
  input  logic [NCH-1:0] high_i,
  output logic [NCH-1:0] clr_o,
  output logic           blank_o
);
  logic blank_w;

  ovl_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit_i),
    .blank_o  (blank_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ovl_chan_guard u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit_i),
      .blank_i  (blank_w),
      .zap_i    (zap_i),
      .on_i     (on_i[g]),
      .high_i   (high_i[g]),
      .clr_o    (clr_o[g])
    );
  end

  assign blank_o = blank_w;

  // R4: blanking suppresses every fault clear
  p_blank_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_o && !zap_i) |=> (clr_o == '0));

  // R9: global clear reaches every channel
  p_zap_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zap_i |=> (&clr_o));
endmodule

// File: tb/sim_ovl_shutdown.sv
module sim_ovl_shutdown;
  localparam int NCH = 8;
  localparam int BL  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic commit_i = 1'b0, zap_i = 1'b0;
  logic [NCH-1:0] on_i = '0, high_i = '0;
  logic [NCH-1:0] clr_o;
  logic blank_o;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  ovl_shutdown #(.NCH(NCH), .BLANK_CYC(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .zap_i(zap_i),
    .on_i(on_i), .high_i(high_i), .clr_o(clr_o), .blank_o(blank_o)
  );

  // {commit, zap, on, high, expected clr, expected blank, requirement}
  localparam logic [30:0] VEC [26] = '{
    {1'b0,1'b0,8'h00,8'hFF,8'h00,1'b0,4'd7},
    {1'b0,1'b0,8'h01,8'h01,8'h01,1'b0,4'd5},
    {1'b0,1'b0,8'h01,8'h01,8'h00,1'b0,4'd8},
    {1'b0,1'b0,8'h00,8'h01,8'h00,1'b0,4'd8},
    {1'b1,1'b0,8'h00,8'h00,8'h00,1'b1,4'd2},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd4},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd4},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd4},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b0,4'd2},
    {1'b0,1'b0,8'h0F,8'h0F,8'h0F,1'b0,4'd5},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b0,4'd8},
    {1'b1,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd4},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd2},
    {1'b1,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd3},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd3},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd3},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b1,4'd3},
    {1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b0,4'd3},
    {1'b0,1'b0,8'h0F,8'h0F,8'h0F,1'b0,4'd5},
    {1'b0,1'b1,8'h00,8'h00,8'hFF,1'b0,4'd9},
    {1'b1,1'b0,8'h00,8'h00,8'h00,1'b1,4'd2},
    {1'b0,1'b1,8'h00,8'h00,8'hFF,1'b1,4'd9},
    {1'b0,1'b0,8'h80,8'h00,8'h00,1'b1,4'd7},
    {1'b0,1'b0,8'hC3,8'h41,8'h00,1'b1,4'd4},
    {1'b0,1'b0,8'hC3,8'h41,8'h00,1'b0,4'd2},
    {1'b0,1'b0,8'hC3,8'h41,8'h41,1'b0,4'd6}
  };

  function automatic string rname(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [NCH-1:0] eclr, input logic eblank);
    n_run++;
    if (clr_o !== eclr || blank_o !== eblank) begin
      n_fail++;
      $display("FAIL %s: clr=%h blank=%b expected clr=%h blank=%b",
               req, clr_o, blank_o, eclr, eblank);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", '0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", '0, 1'b0);

    for (int i = 0; i < 26; i++) begin
      commit_i = VEC[i][30];
      zap_i    = VEC[i][29];
      on_i     = VEC[i][28:21];
      high_i   = VEC[i][20:13];
      @(posedge clk); #1;
      check(rname(int'(VEC[i][3:0])), VEC[i][12:5], VEC[i][4]);
    end

    // R1: reset in the middle of a window ends blanking
    commit_i = 1'b1; on_i = '0; high_i = '0;
    @(posedge clk); #1;
    commit_i = 1'b0;
    check("R2", '0, 1'b1);
    rst_n = 1'b0;
    #2;
    check("R1", '0, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R5: first fault after reset is caught with no blanking
    on_i = 8'h20; high_i = 8'h20;
    @(posedge clk); #1;
    check("R5", 8'h20, 1'b0);
    on_i = '0; high_i = '0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule